// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block sits in front of a digital-to-analog converter. It holds two registers. The first is a staging register. It can be filled one bit at a time from a serial stream, or a whole piece at a time through a parallel piece port. The second is the output register, and it alone drives the converter code. The code moves to the output register only when the update strobe is high at a clock edge.

Several instances can share one update strobe. Each is loaded in turn, and then they all change their converter codes on the same edge. The bit that leaves the top of the staging register appears on a serial output. That output can feed the serial input of the next device in a chain, so one serial source reaches every device. A readback port, enabled by parameter, returns the output register contents.

The serial input is a valid/ready stream, sampled on the system clock. A bit is taken only on a cycle where both valid and ready are high. Ready is low while chip select is high, and also during any cycle in which the piece port writes. A source seeing ready low must hold its bit and valid until ready returns.

Top module: `dac_input_reg`

## Requirements
- R1: After reset, both registers are zero. As a result `dac_code`, `rd_data` and `ser_out` are all zero.
- R2: Each accepted serial bit enters bit 0 of the staging register while the other bits move up one place. A 16-bit word sent most significant bit first, followed by an update, therefore appears unchanged on `dac_code`.
- R3: `dac_code` keeps its value on every edge where `upd` is low, whatever the serial port or piece port do.
- R4: A piece write with `byte_sel`=1 replaces bits 15:8 of the staging register, and `byte_sel`=0 replaces bits 7:0. The other piece is left unchanged.
- R5: `ser_ready` is high only when `cs_n` is low and `byte_we` is low. A piece write therefore wins over a serial bit offered in the same cycle, and that bit is not taken.
- R6: When `upd` is high on the same edge as a serial shift or a piece write, the output register receives the staging contents from before that edge.
- R7: `ser_out` always shows bit 15 of the staging register. During a run of accepted bits it therefore presents the previous contents, most significant bit first.
- R8: With readback enabled, `rd_data` equals `dac_code`.
- R9: While `cs_n` is high, offered serial bits are not taken and the staging register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select for the serial port |
| ser_valid | input | 1 | A serial bit is offered |
| ser_ready | output | 1 | The offered serial bit is taken this cycle |
| ser_data | input | 1 | Serial data bit |
| ser_out | output | 1 | Top bit of the staging register, for chaining |
| byte_we | input | 1 | Piece write strobe |
| byte_sel | input | 1 | Piece index (1 = upper byte) |
| byte_data | input | 8 | Piece value |
| upd | input | 1 | Update strobe: copy staging to output register |
| dac_code | output | 16 | Converter code |
| rd_data | output | 16 | Readback of the output register |

## Verification
The bench goes after an update that lands on the same edge as a shift or a piece write. A design that let the new staging value flow straight through would show a code that was only half loaded. It also checks that a piece write leaves the other piece untouched; a design with a wrong mask would clear or corrupt it. Serial bits offered while chip select is high, or alongside a piece write, must leave no trace in the staging register. A design that still took them would show a shifted word after the next update. The chained output is compared bit by bit against the previous word during each run of accepted bits. An off-by-one shift or a reversed bit order would show up there as a wrong bit on `ser_out`.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;
  localparam int DEF_CODE_W  = 16;
  localparam int DEF_PIECE_W = 8;

  function automatic int sel_width(input int code_w, input int piece_w);
    return (code_w / piece_w > 1) ? $clog2(code_w / piece_w) : 1;
  endfunction
endpackage

// File: rtl/dac_stage_shift.sv
module dac_stage_shift #(
  parameter int CODE_W  = 16,
  parameter int PIECE_W = 8,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [PIECE_W-1:0] wr_piece,
  output logic [CODE_W-1:0]  q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q[wr_sel*PIECE_W +: PIECE_W] <= wr_piece;
    end else if (shift_en) begin
      q <= {q[CODE_W-2:0], din};
    end
  end

  // checker shadow of the previous cycle's write request
  logic [SEL_W-1:0]   sel_d;
  logic [PIECE_W-1:0] piece_d;
  always_ff @(posedge clk) begin
    sel_d   <= wr_sel;
    piece_d <= wr_piece;
  end

  assert_piece_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q[sel_d*PIECE_W +: PIECE_W] == piece_d);

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !wr_en) |=> q == {$past(q[CODE_W-2:0]), $past(din)});

  assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wr_en) |=> $stable(q));

endmodule

// File: rtl/dac_stage_hold.sv
module dac_stage_hold #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  assert_load_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));

endmodule

// File: rtl/dac_input_reg.sv
module dac_input_reg
  import dac_in_pkg::*;
#(
  parameter int CODE_W   = DEF_CODE_W,
  parameter int PIECE_W  = DEF_PIECE_W,
  parameter bit READBACK = 1'b1,
  localparam int SEL_W   = sel_width(CODE_W, PIECE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ser_valid,
  output logic               ser_ready,
  input  logic               ser_data,
  output logic               ser_out,
  input  logic               byte_we,
  input  logic [SEL_W-1:0]   byte_sel,
  input  logic [PIECE_W-1:0] byte_data,
  input  logic               upd,
  output logic [CODE_W-1:0]  dac_code,
  output logic [CODE_W-1:0]  rd_data
);

  logic [CODE_W-1:0] stage_q;
  logic              take_bit;

  assign ser_ready = !cs_n && !byte_we;
  assign take_bit  = ser_valid && ser_ready;

  dac_stage_shift #(
    .CODE_W (CODE_W),
    .PIECE_W(PIECE_W),
    .SEL_W  (SEL_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(take_bit),
    .din     (ser_data),
    .wr_en   (byte_we),
    .wr_sel  (byte_sel),
    .wr_piece(byte_data),
    .q       (stage_q)
  );

  dac_stage_hold #(
    .CODE_W(CODE_W)
  ) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (upd),
    .d    (stage_q),
    .q    (dac_code)
  );

  assign ser_out = stage_q[CODE_W-1];

  generate
    if (READBACK) begin : g_rb
      assign rd_data = dac_code;
    end else begin : g_no_rb
      assign rd_data = '0;
    end
  endgenerate

  assert_ready_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || byte_we) |-> !ser_ready);

  assert_chain_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && !byte_we) |=> ser_out == $past(stage_q[CODE_W-2]));

endmodule

// File: tb/test_dac_input_reg.sv
module test_dac_input_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ser_valid, ser_data, byte_we, upd;
  logic [0:0]  byte_sel;
  logic [7:0]  byte_data;
  logic        ser_ready, ser_out;
  logic [15:0] dac_code, rd_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] exp_stage;
  logic [15:0] exp_code;

  always #5 clk = ~clk;

  dac_input_reg i_dac_input_reg (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .ser_data(ser_data), .ser_out(ser_out),
    .byte_we(byte_we), .byte_sel(byte_sel), .byte_data(byte_data),
    .upd(upd), .dac_code(dac_code), .rd_data(rd_data)
  );

  localparam logic [15:0] WORDS [6] = '{16'hFFFF, 16'h8001, 16'h1234,
                                        16'h0000, 16'hA5C3, 16'h7FFE};

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      finish_run();
    end
  end

  task automatic do_update();
    upd = 1'b1;
    tick();
    upd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; ser_valid = 1'b0; ser_data = 1'b0;
    byte_we = 1'b0; byte_sel = 1'b0; byte_data = 8'h00; upd = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(dac_code == 16'h0, "R1 code", dac_code, 16'h0);
    check(rd_data == 16'h0, "R1 readback", rd_data, 16'h0);
    check(ser_out == 1'b0, "R1 ser_out", 16'(ser_out), 16'h0);
    check(ser_ready == 1'b0, "R5 ready with cs high", 16'(ser_ready), 16'h0);
    exp_stage = 16'h0;
    exp_code  = 16'h0;

    // table of serial words
    foreach (WORDS[k]) begin
      logic [15:0] w;
      logic [15:0] prev;
      w    = WORDS[k];
      prev = exp_stage;
      cs_n = 1'b0;
      ser_valid = 1'b1;
      for (int i = 0; i < 16; i++) begin
        ser_data = w[15-i];
        #1;
        check(ser_ready == 1'b1, "R5 ready", 16'(ser_ready), 16'h1);
        // R7: chained output shows the previous contents, MSB first
        check(ser_out == prev[15-i], "R7 chain bit", 16'(ser_out), 16'(prev[15-i]));
        tick();
      end
      ser_valid = 1'b0;
      cs_n = 1'b1;
      exp_stage = w;
      check(dac_code == exp_code, "R3 code held before update", dac_code, exp_code);
      do_update();
      exp_code = w;
      check(dac_code == w, "R2 serial word", dac_code, w);
      check(rd_data == w, "R8 readback", rd_data, w);
      check(ser_out == w[15], "R7 top bit", 16'(ser_out), 16'(w[15]));
    end

    // R4: piece writes
    byte_we = 1'b1; byte_sel = 1'b1; byte_data = 8'hA5; tick();
    byte_sel = 1'b0; byte_data = 8'h3C; tick();
    byte_we = 1'b0;
    check(dac_code == exp_code, "R3 held after piece writes", dac_code, exp_code);
    do_update();
    check(dac_code == 16'hA53C, "R4 both pieces", dac_code, 16'hA53C);
    byte_we = 1'b1; byte_sel = 1'b1; byte_data = 8'h11; tick();
    byte_we = 1'b0;
    do_update();
    check(dac_code == 16'h113C, "R4 low piece kept", dac_code, 16'h113C);

    // R6: update together with a piece write
    byte_we = 1'b1; byte_sel = 1'b0; byte_data = 8'h77; upd = 1'b1; tick();
    byte_we = 1'b0; upd = 1'b0;
    check(dac_code == 16'h113C, "R6 update with piece write", dac_code, 16'h113C);
    do_update();
    check(dac_code == 16'h1177, "R6 piece lands later", dac_code, 16'h1177);

    // R6: update together with a shift
    cs_n = 1'b0; ser_valid = 1'b1; ser_data = 1'b1; upd = 1'b1; tick();
    ser_valid = 1'b0; cs_n = 1'b1; upd = 1'b0;
    check(dac_code == 16'h1177, "R6 update with shift", dac_code, 16'h1177);
    do_update();
    check(dac_code == 16'h22EF, "R6 shift lands later", dac_code, 16'h22EF);

    // R5: piece write wins over an offered serial bit
    cs_n = 1'b0; ser_valid = 1'b1; ser_data = 1'b1;
    byte_we = 1'b1; byte_sel = 1'b1; byte_data = 8'h00;
    #1;
    check(ser_ready == 1'b0, "R5 ready low during piece write", 16'(ser_ready), 16'h0);
    tick();
    byte_we = 1'b0; ser_valid = 1'b0; cs_n = 1'b1;
    do_update();
    check(dac_code == 16'h00EF, "R5 bit not taken", dac_code, 16'h00EF);

    // R9: chip select high ignores serial bits
    cs_n = 1'b1; ser_valid = 1'b1; ser_data = 1'b1;
    repeat (3) tick();
    ser_valid = 1'b0;
    do_update();
    check(dac_code == 16'h00EF, "R9 cs high no shift", dac_code, 16'h00EF);
    check(ser_out == 1'b0, "R9 ser_out unchanged", 16'(ser_out), 16'h0);

    finish_run();
  end
endmodule